// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block keeps the exception-related fields of a floating-point status register. When an arithmetic unit finishes an operation it presents a strobe together with a 5-bit vector of the IEEE exceptions that operation raised. The recorder compares those flags with a software-written trap-enable mask and decides whether the operation traps. It then rewrites the current-exception field and the trap-type field. It adds to the accrued-exception field only when the operation does not trap. Finally it emits either a trap request or a pulse telling the fetch logic to step the program counter past the instruction.

Several enabled exceptions can arise from one operation. In that case a trapping operation records just one of them, chosen by a fixed priority, so the handler always finds a single cause. A non-trapping operation records every flag it raised. The fields are also presented as one packed status word whose bit positions a neighbouring decoder relies on.

Top module: `fpx_recorder`

## Requirements
- R1: After reset, the trap-enable mask, current field, accrued field and trap-type field are all zero, and neither trapReq nor pcAdvance is high.
- R2: An operation traps when its flags ANDed with the enable mask are nonzero. In the cycle after the strobe, trapReq is high for exactly one cycle and pcAdvance stays low.
- R3: On a trap, the current field holds exactly one bit: the highest-priority bit of (flags AND mask). The priority order from highest to lowest is invalid (bit 4), overflow (bit 3), underflow (bit 2), divide-by-zero (bit 1), inexact (bit 0).
- R4: On an operation that does not trap, the current field becomes the full raised-flag vector, the accrued field becomes its old value ORed with that vector, and pcAdvance is high for exactly one cycle in the cycle after the strobe.
- R5: A trapping operation leaves the accrued field unchanged.
- R6: The 3-bit trap-type field becomes 1 after a trapping operation and 0 after a non-trapping one.
- R7: An operation that raises no flags clears the current field, leaves the accrued field unchanged, and advances the PC.
- R8: A mask write takes effect in the cycle after it is presented. An operation strobed in the same cycle as a mask write is judged against the previous mask.
- R9: The status word places the enable mask at bits 27:23, the trap type at bits 16:14, the accrued field at bits 9:5 and the current field at bits 4:0. All other bits read zero.
- R10: Without a strobe, the current, accrued and trap-type fields hold their values and no pulse is produced.
- R11: trapReq and pcAdvance are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation has completed and opFlags is valid |
| opFlags | input | 5 | Raised exception flags (invalid=4, overflow=3, underflow=2, divzero=1, inexact=0) |
| maskWrEn | input | 1 | Software write of the trap-enable mask |
| maskWrData | input | 5 | New trap-enable mask |
| trapEnMask | output | 5 | Current trap-enable mask |
| curExc | output | 5 | Current-exception field |
| accExc | output | 5 | Accrued-exception field |
| trapType | output | 3 | Trap-type field |
| statusWord | output | 32 | Packed status word |
| trapReq | output | 1 | One-cycle trap request |
| pcAdvance | output | 1 | One-cycle request to step the PC |

## Verification
The assertions check the following on every cycle:
- a strobe is always followed by the right pulse given the live mask;
- the two pulses are exclusive;
- a trap leaves exactly one current bit, trap type 1 and an unchanged accrued field;
- after an advance the accrued field covers the current field;
- idle cycles change nothing.

Which bit wins a multi-flag trap, the same-cycle ordering of mask write and strobe, and the exact accrued contents after long mixed sequences can only be shown by the bench scenarios, which compare against a behavioural model on every clock.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W = 5;
  localparam int FTT_W  = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic opFire;    // an operation is being recorded this edge
    logic takeTrap;  // that operation traps
  } fpxStrobes_t;
endpackage

// File: rtl/fpx_ctrl.sv
module fpx_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic                trapHit,
  output fpx_pkg::fpxStrobes_t strobes,
  output logic                trapReq,
  output logic                pcAdvance
);
  always_comb begin
    strobes.opFire   = opValid;
    strobes.takeTrap = opValid && trapHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapReq   <= 1'b0;
      pcAdvance <= 1'b0;
    end else begin
      trapReq   <= strobes.takeTrap;
      pcAdvance <= strobes.opFire && !strobes.takeTrap;
    end
  end
endmodule

// File: rtl/fpx_datapath.sv
module fpx_datapath #(
  parameter int FLAG_W   = 5,
  parameter int FTT_W    = 3,
  parameter int STATUS_W = 32,
  parameter int MASK_LSB = 23,
  parameter int FTT_LSB  = 14,
  parameter int ACC_LSB  = 5,
  parameter int CUR_LSB  = 0,
  parameter logic [FTT_W-1:0] FTT_IEEE = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fpx_pkg::fpxStrobes_t strobes,
  input  logic [FLAG_W-1:0]    opFlags,
  input  logic                 maskWrEn,
  input  logic [FLAG_W-1:0]    maskWrData,
  output logic                 trapHit,
  output logic [FLAG_W-1:0]    trapEnMask,
  output logic [FLAG_W-1:0]    curExc,
  output logic [FLAG_W-1:0]    accExc,
  output logic [FTT_W-1:0]     trapType,
  output logic [STATUS_W-1:0]  statusWord
);
  logic [FLAG_W-1:0] enabledHit;
  logic [FLAG_W-1:0] pickedFlag;
  logic [FLAG_W-1:0] nextCur;

  assign enabledHit = opFlags & trapEnMask;
  assign trapHit    = |enabledHit;

  // Fixed priority: the highest bit index wins
  for (genvar i = 0; i < FLAG_W; i++) begin : g_prio
    if (i == FLAG_W - 1) begin : g_top
      assign pickedFlag[i] = enabledHit[i];
    end else begin : g_low
      assign pickedFlag[i] = enabledHit[i] & ~(|enabledHit[FLAG_W-1:i+1]);
    end
  end

  assign nextCur = strobes.takeTrap ? pickedFlag : opFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapEnMask <= '0;
    end else if (maskWrEn) begin
      trapEnMask <= maskWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curExc   <= '0;
      accExc   <= '0;
      trapType <= '0;
    end else if (strobes.opFire) begin
      curExc   <= nextCur;
      trapType <= strobes.takeTrap ? FTT_IEEE : '0;
      if (!strobes.takeTrap) begin
        accExc <= accExc | nextCur;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[MASK_LSB +: FLAG_W] = trapEnMask;
    statusWord[FTT_LSB  +: FTT_W]  = trapType;
    statusWord[ACC_LSB  +: FLAG_W] = accExc;
    statusWord[CUR_LSB  +: FLAG_W] = curExc;
  end
endmodule

// File: rtl/fpx_recorder.sv
module fpx_recorder #(
  parameter int FLAG_W   = fpx_pkg::FLAG_W,
  parameter int FTT_W    = fpx_pkg::FTT_W,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [FLAG_W-1:0]   opFlags,
  input  logic                maskWrEn,
  input  logic [FLAG_W-1:0]   maskWrData,
  output logic [FLAG_W-1:0]   trapEnMask,
  output logic [FLAG_W-1:0]   curExc,
  output logic [FLAG_W-1:0]   accExc,
  output logic [FTT_W-1:0]    trapType,
  output logic [STATUS_W-1:0] statusWord,
  output logic                trapReq,
  output logic                pcAdvance
);
  fpx_pkg::fpxStrobes_t strobes;
  logic trapHit;

  fpx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .trapHit(trapHit),
    .strobes(strobes), .trapReq(trapReq), .pcAdvance(pcAdvance)
  );

  fpx_datapath #(
    .FLAG_W(FLAG_W), .FTT_W(FTT_W), .STATUS_W(STATUS_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opFlags(opFlags),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .trapHit(trapHit),
    .trapEnMask(trapEnMask), .curExc(curExc), .accExc(accExc),
    .trapType(trapType), .statusWord(statusWord)
  );
endmodule

// File: rtl/fpx_recorder_chk.sv
module fpx_recorder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [4:0]  opFlags,
  input logic [4:0]  trapEnMask,
  input logic [4:0]  curExc,
  input logic [4:0]  accExc,
  input logic [2:0]  trapType,
  input logic        trapReq,
  input logic        pcAdvance
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(trapReq && pcAdvance));

  a_r2_trap_follows: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && |(opFlags & trapEnMask)) |=> (trapReq && !pcAdvance));

  a_r4_advance_follows: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !(|(opFlags & trapEnMask))) |=> pcAdvance);

  a_r3_single_cause: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> ($countones(curExc) == 1));

  a_r5_acc_held_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $stable(accExc));

  a_r6_trap_type: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (trapType == 3'd1));

  a_r4_acc_covers_cur: assert property (@(posedge clk) disable iff (!rstN)
    pcAdvance |-> ((accExc & curExc) == curExc));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!trapReq && !pcAdvance && $stable(curExc) && $stable(accExc)
                  && $stable(trapType)));
endmodule

bind fpx_recorder fpx_recorder_chk i_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opFlags(opFlags),
  .trapEnMask(trapEnMask), .curExc(curExc), .accExc(accExc),
  .trapType(trapType), .trapReq(trapReq), .pcAdvance(pcAdvance)
);

// File: tb/test_fpx_recorder.sv
module test_fpx_recorder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opFlags = '0;
  logic        maskWrEn = 1'b0;
  logic [4:0]  maskWrData = '0;
  logic [4:0]  trapEnMask, curExc, accExc;
  logic [2:0]  trapType;
  logic [31:0] statusWord;
  logic        trapReq, pcAdvance;

  int nTests = 0;
  int nFail  = 0;

  // Reference state
  logic [4:0] mMask = '0, mCur = '0, mAcc = '0;
  logic [2:0] mTt = '0;
  logic       mTrap = 1'b0, mAdv = 1'b0;

  always #10 clk = ~clk;

  fpx_recorder i_fpx_recorder (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opFlags(opFlags),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .trapEnMask(trapEnMask),
    .curExc(curExc), .accExc(accExc), .trapType(trapType),
    .statusWord(statusWord), .trapReq(trapReq), .pcAdvance(pcAdvance)
  );

  function automatic logic [4:0] winner(input logic [4:0] v);
    // priority list: invalid, overflow, underflow, divzero, inexact
    int order[5] = '{4, 3, 2, 1, 0};
    winner = '0;
    foreach (order[k]) begin
      if (v[order[k]] && winner == 5'd0) winner[order[k]] = 1'b1;
    end
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = '0; mCur = '0; mAcc = '0; mTt = '0; mTrap = 0; mAdv = 0;
    end else begin
      logic [4:0] hit;
      hit = opFlags & mMask;
      mTrap = 0; mAdv = 0;
      if (opValid) begin
        if (hit != 0) begin
          mCur = winner(hit); mTt = 3'd1; mTrap = 1;
        end else begin
          mCur = opFlags; mAcc = mAcc | opFlags; mTt = 3'd0; mAdv = 1;
        end
      end
      if (maskWrEn) mMask = maskWrData;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R3/R4/R7 curExc", {27'd0, curExc}, {27'd0, mCur});
      check("R4/R5 accExc", {27'd0, accExc}, {27'd0, mAcc});
      check("R6 trapType", {29'd0, trapType}, {29'd0, mTt});
      check("R2/R11 trapReq", {31'd0, trapReq}, {31'd0, mTrap});
      check("R4/R11 pcAdvance", {31'd0, pcAdvance}, {31'd0, mAdv});
      check("R8 trapEnMask", {27'd0, trapEnMask}, {27'd0, mMask});
      check("R9 statusWord", statusWord,
            {4'd0, mMask, 6'd0, mTt, 4'd0, mAcc, mCur});
    end
  end

  task automatic op(input logic [4:0] f);
    @(negedge clk);
    opValid = 1; opFlags = f;
    @(negedge clk);
    opValid = 0; opFlags = '0;
  endtask

  task automatic setMask(input logic [4:0] m);
    @(negedge clk);
    maskWrEn = 1; maskWrData = m;
    @(negedge clk);
    maskWrEn = 0;
  endtask

  initial begin
    #5000000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset fields", statusWord, 32'd0);
    check("R1 reset pulses", {30'd0, trapReq, pcAdvance}, 32'd0);
    rstN = 1;
    @(negedge clk);

    // R4: nothing enabled, flags accrue
    op(5'b00101);
    op(5'b10000);
    check("R4 accrued union", {27'd0, accExc}, 32'h15);
    // R7: no flags clears current, keeps accrued
    op(5'b00000);
    check("R7 cur cleared", {27'd0, curExc}, 32'd0);
    check("R7 acc kept", {27'd0, accExc}, 32'h15);
    // R10: idle cycles hold
    repeat (4) @(negedge clk);
    check("R10 idle hold", {27'd0, accExc}, 32'h15);

    // R3: multiple enabled, priority pick
    setMask(5'b11111);
    op(5'b01110);
    check("R3 overflow wins", {27'd0, curExc}, 32'h08);
    check("R5 acc unchanged", {27'd0, accExc}, 32'h15);
    op(5'b11111);
    check("R3 invalid wins", {27'd0, curExc}, 32'h10);
    setMask(5'b00011);
    op(5'b01011);
    check("R3 masked divzero wins", {27'd0, curExc}, 32'h02);
    op(5'b01100);  // only disabled flags -> no trap
    check("R6 type cleared", {29'd0, trapType}, 32'd0);

    // R8: same-cycle mask write and op uses old mask
    @(negedge clk);
    maskWrEn = 1; maskWrData = 5'b00000; opValid = 1; opFlags = 5'b00001;
    @(negedge clk);
    maskWrEn = 0; opValid = 0; opFlags = '0;
    check("R8 old mask trapped", {31'd0, trapReq}, 32'd1);
    check("R8 new mask visible", {27'd0, trapEnMask}, 32'd0);

    // Back-to-back and random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      opValid = ($urandom % 3) != 0;
      opFlags = 5'($urandom);
      maskWrEn = ($urandom % 7) == 0;
      maskWrData = 5'($urandom);
    end
    @(negedge clk);
    opValid = 0; maskWrEn = 0;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule